// File: doc/BRIEF.md
# Range Cache-Operation Step Length Unit

This combinational unit serves one execution of a range-based cache maintenance instruction. Software hands it a starting byte address and the number of bytes it still wants covered. The unit reports how many bytes this execution actually covers, on the assumption that the hardware touches at most one cache block per execution. It also reports the advanced address and the bytes left over, so the software loop can step its pointers without extra arithmetic.

The step length is formed only from the block-offset bits of the address and the low bits of the request. It uses narrow adders whose width is set by the block size, never by the address width. The advanced address and the leftover length are built from the same narrow sums, and only an incrementer or decrementer works on the upper bits. A step of zero tells software that no work was done. A skip input forces a zero step, which models an implementation that drops optional (hint) operations. Block size is a parameter with a default of 64 bytes.

Top module: `range_step_calc`

## Requirements
- R1: With the address offset within the block equal to zero, skip low and a request of at least BLK_BYTES (default 64), step_len equals BLK_BYTES.
- R2: For a nonzero offset `off` (address bits [log2(BLK_BYTES)-1:0]) and skip low, step_len equals the smaller of BLK_BYTES-off and the request, so a step never crosses a block boundary.
- R3: A request of zero gives step_len zero, no_progress high, next_addr equal to the start address and left_len zero.
- R4: With skip high, step_len is zero, next_addr equals the start address and left_len equals the request, whatever the address and request are.
- R5: next_addr equals the start address plus step_len modulo 2^ADDR_W, including the carry into the bits above the block offset and wrap-around at the top of the address space.
- R6: left_len equals the request minus step_len, including a borrow out of the low request bits into the upper bits.
- R7: no_progress is high exactly when step_len is zero.
- R8: range_done is high exactly when left_len is zero.
- R9: step_len never exceeds BLK_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| start_addr | input | ADDR_W | Byte address where this execution begins |
| req_len | input | LEN_W | Bytes software still wants covered |
| skip | input | 1 | Forces a zero step (optional operation dropped) |
| step_len | output | LEN_W | Bytes covered by this execution |
| next_addr | output | ADDR_W | start_addr advanced by step_len |
| left_len | output | LEN_W | req_len reduced by step_len |
| no_progress | output | 1 | High when step_len is zero |
| range_done | output | 1 | High when left_len is zero |

## Verification
Two functions can fall together on a single input vector: the carry of the low address sum into the upper address bits and the borrow of the low length difference out of the upper request bits. A start address just below a block boundary, with the bits above it all ones, and a request whose low bits are smaller than the step provoke both at once. The next address is then judged against a wide sum and the leftover length against a wide difference, both computed in the bench. Skip and a zero request also meet on one vector, and there both must give a zero step with the request returned unchanged.

// File: rtl/range_step_calc.sv
module range_step_calc #(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 64,
  parameter int BLK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              skip,
  output logic [LEN_W-1:0]  step_len,
  output logic [ADDR_W-1:0] next_addr,
  output logic [LEN_W-1:0]  left_len,
  output logic              no_progress,
  output logic              range_done
);
  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int NW    = OFF_W + 1;
  localparam int AH_W  = ADDR_W - OFF_W;
  localparam int LH_W  = LEN_W - NW;
  localparam logic [NW-1:0] BLK_N = NW'(BLK_BYTES);

  logic [OFF_W-1:0] off;
  logic [NW-1:0]    room;
  logic [NW-1:0]    req_lo;
  logic             req_hi_any;
  logic             covers_room;
  logic [NW-1:0]    step_n;

  assign off         = start_addr[OFF_W-1:0];
  assign room        = BLK_N - {1'b0, off};
  assign req_lo      = req_len[NW-1:0];
  assign req_hi_any  = |req_len[LEN_W-1:NW];
  assign covers_room = req_hi_any || (req_lo >= room);
  assign step_n      = skip ? '0 : (covers_room ? room : req_lo);

  logic [NW-1:0]   addr_lo_sum;
  logic [AH_W-1:0] addr_hi;

  assign addr_lo_sum = {1'b0, off} + step_n;
  assign addr_hi     = start_addr[ADDR_W-1:OFF_W] + AH_W'(addr_lo_sum[OFF_W]);
  assign next_addr   = {addr_hi, addr_lo_sum[OFF_W-1:0]};

  logic [NW:0]     len_lo_diff;
  logic [LH_W-1:0] len_hi;

  assign len_lo_diff = {1'b0, req_lo} - {1'b0, step_n};
  assign len_hi      = req_len[LEN_W-1:NW] - LH_W'(len_lo_diff[NW]);
  assign left_len    = {len_hi, len_lo_diff[NW-1:0]};

  assign step_len    = LEN_W'(step_n);
  assign no_progress = (step_n == '0);
  assign range_done  = (left_len == '0);
endmodule

// File: rtl/range_step_calc_chk.sv
module range_step_calc_chk #(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 64,
  parameter int BLK_BYTES = 64
) (
  input logic [ADDR_W-1:0] start_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              skip,
  input logic [LEN_W-1:0]  step_len,
  input logic [ADDR_W-1:0] next_addr,
  input logic [LEN_W-1:0]  left_len,
  input logic              no_progress,
  input logic              range_done
);
  localparam int OFF_W = $clog2(BLK_BYTES);

  always_comb begin
    assert_step_cap_R9: assert (step_len <= LEN_W'(BLK_BYTES));
    if (skip)
      assert_skip_zero_R4: assert (step_len == '0 && left_len == req_len);
    if (no_progress)
      assert_idle_keeps_R7: assert (next_addr == start_addr && left_len == req_len);
    assert_addr_step_R5: assert (LEN_W'(next_addr - start_addr) == step_len);
    assert_len_balance_R6: assert (left_len + step_len == req_len);
    if (!skip && start_addr[OFF_W-1:0] == '0 && req_len >= LEN_W'(BLK_BYTES))
      assert_aligned_full_R1: assert (step_len == LEN_W'(BLK_BYTES));
    if (range_done)
      assert_done_match_R8: assert (step_len == req_len);
  end
endmodule

bind range_step_calc range_step_calc_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)
) u_chk (
  .start_addr(start_addr), .req_len(req_len), .skip(skip),
  .step_len(step_len), .next_addr(next_addr), .left_len(left_len),
  .no_progress(no_progress), .range_done(range_done)
);

// File: tb/range_step_calc_test.sv
module range_step_calc_test;
  localparam int AW  = 64;
  localparam int LW  = 64;
  localparam int BLK = 64;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [LW-1:0] len;
    logic          skp;
    logic [LW-1:0] e_step;
    logic [AW-1:0] e_next;
    logic [LW-1:0] e_left;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{64'h1000, 64'h40, 1'b0, 64'h40, 64'h1040, 64'h0},
    '{64'h1000, 64'h1000, 1'b0, 64'h40, 64'h1040, 64'hFC0},
    '{64'h1010, 64'h100, 1'b0, 64'h30, 64'h1040, 64'hD0},
    '{64'h103F, 64'h5, 1'b0, 64'h1, 64'h1040, 64'h4},
    '{64'h1008, 64'h10, 1'b0, 64'h10, 64'h1018, 64'h0},
    '{64'h2000, 64'h0, 1'b0, 64'h0, 64'h2000, 64'h0},
    '{64'h2000, 64'h80, 1'b1, 64'h0, 64'h2000, 64'h80},
    '{64'hFFFF_FFC0, 64'h40, 1'b0, 64'h40, 64'h1_0000_0000, 64'h0},
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'h1_0000_0000, 1'b0, 64'h10, 64'h0, 64'hFFFF_FFF0},
    '{64'h20, 64'h100, 1'b0, 64'h20, 64'h40, 64'hE0},
    '{64'h2A7, 64'h0, 1'b1, 64'h0, 64'h2A7, 64'h0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] start_addr;
  logic [LW-1:0] req_len;
  logic          skip;
  logic [LW-1:0] step_len;
  logic [AW-1:0] next_addr;
  logic [LW-1:0] left_len;
  logic          no_progress;
  logic          range_done;

  range_step_calc #(.ADDR_W(AW), .LEN_W(LW), .BLK_BYTES(BLK)) uut (
    .start_addr(start_addr), .req_len(req_len), .skip(skip),
    .step_len(step_len), .next_addr(next_addr), .left_len(left_len),
    .no_progress(no_progress), .range_done(range_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] a, input logic [LW-1:0] l, input logic s);
    @(negedge clk);
    start_addr = a; req_len = l; skip = s;
    #5;
  endtask

  task automatic check_all(input string req, input logic [LW-1:0] es,
                           input logic [AW-1:0] en, input logic [LW-1:0] el);
    check({req, " step"}, step_len, es);
    check({req, " next R5"}, next_addr, en);
    check({req, " left R6"}, left_len, el);
    check({req, " idle R7"}, 64'(no_progress), 64'(es == '0));
    check({req, " done R8"}, 64'(range_done), 64'(el == '0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    start_addr = '0; req_len = '0; skip = 1'b1;
    apply('0, '0, 1'b1);
    check_all("R4 initial", 64'h0, 64'h0, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].addr, VECS[i].len, VECS[i].skp);
      check_all("R1/R2/R3/R4 table", VECS[i].e_step, VECS[i].e_next, VECS[i].e_left);
    end

    for (int off = 0; off < BLK; off++) begin
      for (int len = 0; len <= 3 * BLK; len++) begin
        logic [AW-1:0] a;
        logic [LW-1:0] es;
        int room;
        a = 64'h0000_1234_5678_9A00 + 64'(off);
        room = BLK - off;
        es = 64'((len < room) ? len : room);
        apply(a, 64'(len), 1'b0);
        check("R2 sweep step", step_len, es);
        check("R9 sweep cap", 64'(step_len <= 64'(BLK)), 64'h1);
        check("R5 sweep next", next_addr, a + es);
        check("R6 sweep left", left_len, 64'(len) - es);
        check("R7 sweep idle", 64'(no_progress), 64'(es == '0));
        check("R8 sweep done", 64'(range_done), 64'(64'(len) == es));
      end
    end

    apply(64'hABC0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    check_all("R1 huge request", 64'h40, 64'hAC00, 64'hFFFF_FFFF_FFFF_FFBF);
    apply(64'hFFFF_FFFF_FFFF_FFC0, 64'h40, 1'b0);
    check_all("R5 wrap", 64'h40, 64'h0, 64'h0);
    apply(64'h13, 64'h0, 1'b0);
    check_all("R3 zero request", 64'h0, 64'h13, 64'h0);
    apply(64'h13, 64'hFFFF, 1'b1);
    check_all("R4 skip unaligned", 64'h0, 64'h13, 64'hFFFF);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule